// File: doc/BRIEF.md
# Multi-Octave Time-Shared Wavelet Filter Engine

This block computes a one-dimensional discrete wavelet transform over several octaves from a serial stream of signed samples. Each cycle can carry one sample, marked by a valid flag. A single lowpass/highpass pair of parallel FIR filters does the work for every octave. Each octave keeps its own short serial-in parallel-out history. The octave i history advances once every 2^(i-1) accepted samples, and its window reaches the filters once every 2^i accepted samples.

A slot counter decides which octave owns the filter pair. The counter counts accepted samples modulo 2^J. The number of trailing one bits in its value names the octave. This is a fixed offset on the plain pyramid timing, so no two octaves ever ask for the filters in the same slot. One slot in every 2^J has J trailing ones, and that spare slot releases the lowpass result of the last octave. As a result, every accepted sample gives exactly one output beat, and N samples take N cycles. Each beat carries an octave number and a band flag. The lowpass results of octaves below J stay inside the block and feed the next octave's history.

The coefficients are fixed-point constants. The default is a four-tap Daubechies pair in Q1.14. A two-tap Haar pair is available as a variant. All histories start at zero, so the start of the stream is zero padded.

Top module: `dwt_mrpa_top`

## Requirements
- R1: A synchronous active-high reset clears every history, the slot counter and the parked lowpass value. The cycle after a reset edge shows out_valid = 0. The first outputs after reset are computed as if all earlier samples were zero.
- R2: out_valid is 1 in the cycle after each cycle with in_valid = 1 (outside reset), and 0 in every other cycle.
- R3: Let t be the number of samples accepted since reset, taken modulo 2^J, and let k be the number of trailing one bits of t. If k < J, the beat for that sample has out_octave = k+1 and out_band = 1 (high). If k = J, the beat has out_octave = J and out_band = 0 (low).
- R4: The octave-1 highpass beat for sample t equals the highpass filter applied to the window x[t-1], x[t-2], …, x[t-L] (newest first, zero for negative indices), taken before sample t enters the history.
- R5: When octave i < J fires, its lowpass result is pushed into the octave i+1 history. Octave i+1 filters the L most recent such values, newest first.
- R6: The lowpass result of octave J is computed in its firing slot, held in a register, and emitted at the next spare slot (k = J) as a band-0 beat.
- R7: Each filter output is the sum of coefficient times tap, plus 2^13, shifted arithmetically right by 14, and then saturated to the range −32768 to 32767.
- R8: A cycle with in_valid = 0 produces no output. It also leaves the slot counter and all histories unchanged, so the transform of the accepted samples does not depend on gaps.
- R9: With L = 4, the lowpass taps are h = (7913, 13705, 3672, −2120) and the highpass taps are g = (−2120, −3672, 13705, −7913), where tap j multiplies the j-th newest history entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | W (16) | Signed input sample |
| out_valid | output | 1 | Output beat present |
| out_coef | output | W (16) | Signed wavelet coefficient |
| out_octave | output | OW (2) | Octave number, 1..J |
| out_band | output | 1 | 1 = highpass, 0 = lowpass |

## Verification
Every beat appears exactly one clock after the cycle in which its sample is accepted. The one exception in content is the last-octave lowpass value: it is produced 2^(J-1) accepted samples before the spare slot that carries it, so it reaches the port at the edge after that spare slot. The bench drives each input on a falling edge and compares the outputs at the next falling edge. At that point the model's expectation for the previous cycle's stimulus is already settled. Idle cycles are compared as well, to confirm that no beat appears and that the schedule resumes where it left off.

// File: rtl/dwt_mrpa_pkg.sv
package dwt_mrpa_pkg;

   localparam int CW   = 16;  // coefficient width
   localparam int FRAC = 14;  // fractional bits of the coefficients

   typedef enum logic {
      BAND_LO = 1'b0,
      BAND_HI = 1'b1
   } band_e;

   // lowpass analysis tap j (j = 0 multiplies the newest sample)
   function automatic logic signed [CW-1:0] lo_tap(input int taps, input int j);
      int v;
      v = 0;
      if (taps == 2) begin
         v = 11585;
      end else begin
         case (j)
            0:       v = 7913;
            1:       v = 13705;
            2:       v = 3672;
            default: v = -2120;
         endcase
      end
      return v[CW-1:0];
   endfunction

   // highpass tap: alternating-sign mirror of the lowpass set
   function automatic logic signed [CW-1:0] hi_tap(input int taps, input int j);
      logic signed [CW-1:0] m;
      m = lo_tap(taps, taps - 1 - j);
      return (j % 2 == 1) ? -m : m;
   endfunction

endpackage

// File: rtl/dwt_slot_sched.sv
module dwt_slot_sched #(
   parameter int J = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [J-1:0] fire,
   output logic         spare,
   output logic [J-1:0] cnt
);

   logic [J-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

   // octave i+1 owns the filters when cnt has exactly i trailing ones
   generate
      for (genvar i = 0; i < J; i++) begin : g_fire
         if (i == 0) begin : g_first
            assign fire[i] = adv & ~cnt_q[0];
         end else begin : g_upper
            assign fire[i] = adv & (&cnt_q[i-1:0]) & ~cnt_q[i];
         end
      end
   endgenerate

   assign spare = adv & (&cnt_q);

endmodule

// File: rtl/dwt_sipo_bank.sv
module dwt_sipo_bank #(
   parameter int W = 16,
   parameter int L = 4,
   parameter int J = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [J-1:0]        push,
   input  logic signed [W-1:0] din [J],
   output logic signed [W-1:0] q   [J][L]
);

   generate
      for (genvar i = 0; i < J; i++) begin : g_oct
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int k = 0; k < L; k++) q[i][k] <= '0;
            end else if (push[i]) begin
               q[i][0] <= din[i];
               for (int k = 1; k < L; k++) q[i][k] <= q[i][k-1];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/dwt_fir.sv
module dwt_fir
   import dwt_mrpa_pkg::*;
#(
   parameter int W    = 16,
   parameter int L    = 4,
   parameter bit HIGH = 1'b0
) (
   input  logic signed [W-1:0] taps [L],
   output logic signed [W-1:0] y
);

   localparam int AW = W + CW + $clog2(L) + 1;
   localparam int NODES = 2 * L - 1;
   localparam logic signed [AW-1:0] HALF = AW'(1) <<< (FRAC - 1);
   localparam logic signed [AW-1:0] MAXV = AW'((1 <<< (W - 1)) - 1);
   localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

   logic signed [AW-1:0] node [NODES];
   logic signed [AW-1:0] biased;
   logic signed [AW-1:0] scaled;

   generate
      // leaves: one constant multiplier per tap
      for (genvar j = 0; j < L; j++) begin : g_mul
         localparam logic signed [CW-1:0] C = HIGH ? hi_tap(L, j) : lo_tap(L, j);
         assign node[L-1+j] = AW'(taps[j]) * AW'(C);
      end
      // balanced adder tree, log2(L) levels deep
      for (genvar n = 0; n < L - 1; n++) begin : g_add
         assign node[n] = node[2*n+1] + node[2*n+2];
      end
   endgenerate

   always_comb begin
      biased = node[0] + HALF;
      scaled = biased >>> FRAC;
      if (scaled > MAXV)      y = MAXV[W-1:0];
      else if (scaled < MINV) y = MINV[W-1:0];
      else                    y = scaled[W-1:0];
   end

endmodule

// File: rtl/dwt_mrpa_top.sv
module dwt_mrpa_top
   import dwt_mrpa_pkg::*;
#(
   parameter int W  = 16,
   parameter int L  = 4,
   parameter int J  = 3,
   parameter int OW = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_sample,
   output logic                out_valid,
   output logic signed [W-1:0] out_coef,
   output logic [OW-1:0]       out_octave,
   output logic                out_band
);

   // elaboration-time parameter checks
   generate
      if (!(L == 2 || L == 4)) begin : g_bad_taps
         $error("dwt_mrpa_top: L must be 2 or 4");
      end
      if (J < 1 || J >= (1 << OW)) begin : g_bad_octaves
         $error("dwt_mrpa_top: J must be in 1..2**OW-1");
      end
      if (W < 4) begin : g_bad_width
         $error("dwt_mrpa_top: W too small");
      end
   endgenerate

   logic [J-1:0]        fire_vec;
   logic                spare_slot;
   logic [J-1:0]        slot_cnt;
   logic [J-1:0]        push;
   logic signed [W-1:0] din  [J];
   logic signed [W-1:0] hist [J][L];
   logic signed [W-1:0] win  [L];
   logic signed [W-1:0] lo_y;
   logic signed [W-1:0] hi_y;
   logic signed [W-1:0] park_q;
   logic [OW-1:0]       fire_oct;
   logic                any_fire;

   dwt_slot_sched #(.J(J)) u_sched (
      .clk   (clk),
      .rst   (rst),
      .adv   (in_valid),
      .fire  (fire_vec),
      .spare (spare_slot),
      .cnt   (slot_cnt)
   );

   // history write routing: raw samples into octave 1, lowpass cascade above
   generate
      if (J > 1) begin : g_push_multi
         assign push = {fire_vec[J-2:0], in_valid};
      end else begin : g_push_single
         assign push = in_valid;
      end
   endgenerate

   always_comb begin
      din[0] = in_sample;
      for (int i = 1; i < J; i++) din[i] = lo_y;
   end

   dwt_sipo_bank #(.W(W), .L(L), .J(J)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .push (push),
      .din  (din),
      .q    (hist)
   );

   // window select for the octave that owns the filters this cycle
   always_comb begin
      for (int k = 0; k < L; k++) win[k] = '0;
      fire_oct = '0;
      for (int i = 0; i < J; i++) begin
         if (fire_vec[i]) begin
            for (int k = 0; k < L; k++) win[k] = hist[i][k];
            fire_oct = OW'(i + 1);
         end
      end
   end

   assign any_fire = |fire_vec;

   dwt_fir #(.W(W), .L(L), .HIGH(1'b0)) u_lo (
      .taps (win),
      .y    (lo_y)
   );

   dwt_fir #(.W(W), .L(L), .HIGH(1'b1)) u_hi (
      .taps (win),
      .y    (hi_y)
   );

   // last-octave lowpass waits for the spare slot
   always_ff @(posedge clk) begin
      if (rst) begin
         park_q <= '0;
      end else if (fire_vec[J-1]) begin
         park_q <= lo_y;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid  <= 1'b0;
         out_coef   <= '0;
         out_octave <= '0;
         out_band   <= BAND_LO;
      end else begin
         out_valid <= in_valid;
         if (any_fire) begin
            out_coef   <= hi_y;
            out_octave <= fire_oct;
            out_band   <= BAND_HI;
         end else if (spare_slot) begin
            out_coef   <= park_q;
            out_octave <= OW'(J);
            out_band   <= BAND_LO;
         end
      end
   end

endmodule

// File: rtl/dwt_mrpa_chk.sv
module dwt_mrpa_chk #(
   parameter int J  = 3,
   parameter int OW = 2
) (
   input logic          clk,
   input logic          rst,
   input logic          in_valid,
   input logic          out_valid,
   input logic          out_band,
   input logic [OW-1:0] out_octave,
   input logic [J-1:0]  fire,
   input logic [J-1:0]  slot_cnt
);

   p_beat_follows_r2: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   p_one_owner_r3: assert property (@(posedge clk) disable iff (rst)
      $onehot0(fire));

   p_octave_legal_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_octave >= OW'(1)) && (out_octave <= OW'(J)));

   p_slot_step_r3: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> slot_cnt == J'($past(slot_cnt) + 1'b1));

   p_low_only_last_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_band) |-> out_octave == OW'(J));

   p_gap_holds_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(slot_cnt));

   p_gap_no_owner_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |-> fire == '0);

endmodule

bind dwt_mrpa_top dwt_mrpa_chk #(.J(J), .OW(OW)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .out_band   (out_band),
   .out_octave (out_octave),
   .fire       (fire_vec),
   .slot_cnt   (slot_cnt)
);

// File: tb/dwt_mrpa_top_bench.sv
module dwt_mrpa_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int W  = 16;
   localparam int L  = 4;
   localparam int J  = 3;
   localparam int OW = 2;

   logic                clk = 1'b0;
   logic                rst;
   logic                in_valid;
   logic signed [W-1:0] in_sample;
   logic                out_valid;
   logic signed [W-1:0] out_coef;
   logic [OW-1:0]       out_octave;
   logic                out_band;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dwt_mrpa_top #(.W(W), .L(L), .J(J), .OW(OW)) u_dwt_mrpa_top (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .out_valid  (out_valid),
      .out_coef   (out_coef),
      .out_octave (out_octave),
      .out_band   (out_band)
   );

   // reference taps (R9)
   int H [L] = '{7913, 13705, 3672, -2120};
   int G [L] = '{-2120, -3672, 13705, -7913};

   int  checks = 0;
   int  errors = 0;
   bit  armed = 0;
   bit  finished = 0;

   // behavioural model state
   int  hist [J+1][$];
   int  park;
   bit  park_sat;
   int  slot;
   bit  exp_valid;
   bit  exp_after_rst;
   int  exp_oct;
   int  exp_band;
   int  exp_coef;
   bit  exp_sat;

   // impulse bookkeeping
   bit  imp_phase;
   int  out_idx;

   function automatic int rnd_sat(input longint acc, output bit sat);
      longint r;
      r = (acc + 64'sd8192) >>> 14;
      sat = 0;
      if (r > 32767)       begin r = 32767;  sat = 1; end
      else if (r < -32768) begin r = -32768; sat = 1; end
      return int'(r);
   endfunction

   task automatic model_reset();
      for (int i = 0; i <= J; i++) hist[i].delete();
      park = 0;
      park_sat = 0;
      slot = 0;
   endtask

   task automatic model_slot(input int x);
      int t, k, oct, v, lo, hi;
      longint al, ah;
      bit sl, sh;
      t = slot % (1 << J);
      k = 0;
      while (k < J && ((t >> k) & 1) == 1) k++;
      if (k < J) begin
         oct = k + 1;
         al = 0;
         ah = 0;
         for (int j = 0; j < L; j++) begin
            v = (j < hist[oct].size()) ? hist[oct][j] : 0;
            al += longint'(H[j]) * v;
            ah += longint'(G[j]) * v;
         end
         lo = rnd_sat(al, sl);
         hi = rnd_sat(ah, sh);
         exp_oct = oct;
         exp_band = 1;
         exp_coef = hi;
         exp_sat = sh;
         if (oct < J) begin
            hist[oct+1].push_front(lo);
            if (hist[oct+1].size() > L) void'(hist[oct+1].pop_back());
         end else begin
            park = lo;
            park_sat = sl;
         end
      end else begin
         exp_oct = J;
         exp_band = 0;
         exp_coef = park;
         exp_sat = park_sat;
      end
      hist[1].push_front(x);
      if (hist[1].size() > L) void'(hist[1].pop_back());
      slot++;
   endtask

   task automatic fail(input string req, input string what, input int act, input int exp);
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
   endtask

   task automatic do_check();
      string lab;
      checks++;
      if (out_valid !== exp_valid) begin
         lab = exp_after_rst ? "R1" : (exp_valid ? "R2" : "R8");
         fail(lab, "out_valid", int'(out_valid), int'(exp_valid));
      end
      if (exp_valid && out_valid === 1'b1) begin
         checks++;
         if (int'(out_octave) != exp_oct || int'(out_band) != exp_band)
            fail("R3", "octave*2+band", int'(out_octave) * 2 + int'(out_band),
                 exp_oct * 2 + exp_band);
         checks++;
         if (exp_sat) lab = "R7";
         else if (exp_band == 0) lab = "R6";
         else if (exp_oct > 1) lab = "R5";
         else lab = "R4";
         if (int'(out_coef) != exp_coef) fail(lab, "out_coef", int'(out_coef), exp_coef);
         // directed impulse response, coefficient values (R9)
         if (imp_phase && out_idx == 2) begin
            checks++;
            if (int'(out_coef) != -3672) fail("R9", "impulse g1", int'(out_coef), -3672);
         end
         if (imp_phase && out_idx == 4) begin
            checks++;
            if (int'(out_coef) != -7913) fail("R9", "impulse g3", int'(out_coef), -7913);
         end
         out_idx++;
      end
   endtask

   // one cycle: check previous result, drive new stimulus, advance model
   task automatic step(input bit v, input int x, input bit r);
      @(negedge clk);
      if (armed) do_check();
      armed = 1;
      rst = r;
      in_valid = v;
      in_sample = x[W-1:0];
      exp_after_rst = r;
      exp_sat = 0;
      if (r) begin
         model_reset();
         exp_valid = 0;
         out_idx = 0;
      end else if (v) begin
         model_slot(x);
         exp_valid = 1;
      end else begin
         exp_valid = 0;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin : stim
      rst = 1'b1;
      in_valid = 1'b0;
      in_sample = '0;
      imp_phase = 0;
      out_idx = 0;
      exp_valid = 0;
      exp_after_rst = 1;
      model_reset();

      // R1: reset state
      repeat (3) step(0, 0, 1);
      step(0, 0, 0);

      // R9: impulse at sample 0 then zeros
      imp_phase = 1;
      step(1, 16384, 0);
      repeat (15) step(1, 0, 0);
      step(0, 0, 0);
      imp_phase = 0;

      // R4/R5/R6: ramp, continuous valid
      step(0, 0, 1);
      for (int n = 0; n < 64; n++) step(1, n * 37 - 900, 0);

      // R7: alternating full-scale input drives the highpass into saturation
      for (int n = 0; n < 32; n++) step(1, (n % 2 == 0) ? 32767 : -32768, 0);
      // constant full scale saturates the lowpass cascade
      for (int n = 0; n < 32; n++) step(1, 32767, 0);

      // R8: gaps between samples
      for (int n = 0; n < 40; n++) begin
         step(1, n * 211 - 4000, 0);
         repeat (n % 3) step(0, 12345, 0);
      end

      // R1: reset mid stream, then restart from zero history
      step(1, 5000, 1);
      for (int n = 0; n < 24; n++) step(1, 3000 - n * 250, 0);

      // random traffic with random gaps
      for (int n = 0; n < 4000; n++) begin
         int x;
         bit v;
         v = ($urandom_range(0, 9) < 7);
         x = int'($urandom_range(0, 40000)) - 20000;
         step(v, x, 0);
      end

      step(0, 0, 0);
      step(0, 0, 0);
      finish_run();
   end

endmodule